// File: doc/BRIEF.md
# Clamped Multiply Dataflow Accelerator

This block is a fixed-function streaming datapath. It replaces a short run of straight-line integer code with three register stages. Each accepted sample carries three signed words, `x`, `y` and `q`. The block forms a sum of `x` and `y`, and it scales `y` by seven using a shift followed by a subtract. A negative scaled value is forced to zero. A correction is then applied to the sum: a bonus when `q` matches a fixed key, and a penalty otherwise. The result is the product of the clamped value and the corrected sum.

The block has no branches. Both arms of each conditional are computed in parallel, and a multiplexer keeps one of them. The interface is a valid-qualified stream with no backpressure. A sample can be offered on every clock cycle, and each accepted sample produces exactly one result a fixed number of cycles later. All arithmetic wraps modulo 2^32, the same way a 32-bit C `int` behaves.

Top module: `clamp_mul_pipe`

## Requirements
- R1: The sum `z` is `in_x + in_y` taken modulo 2^32, so a carry out of bit 31 is discarded.
- R2: The scaled value is `(in_y << 3) - in_y` modulo 2^32, which is 7·y wrapped. When bit 31 of the scaled value is set it is replaced by zero, and otherwise it passes unchanged.
- R3: The corrected sum is `z + 5` when all 32 bits of `in_q` equal the value 3. For every other value of `in_q`, including ones whose low bits are 3, it is `z - 2`, taken modulo 2^32.
- R4: `out_j` is the low 32 bits of the product of the clamped scaled value and the corrected sum.
- R5: `out_valid` is high exactly three rising edges after the edge at which `in_valid` was sampled high. `out_j` belongs to that same sample.
- R6: A sample is accepted on every edge at which `in_valid` is high, and back-to-back samples give back-to-back results in order. An edge with `in_valid` low produces a cycle with `out_valid` low three edges later.
- R7: Reset is synchronous and active low. While `rst_n` is low at an edge, every stage valid bit clears, so `out_valid` is low after that edge. Samples that were in flight before the reset never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid bits |
| in_valid | input | 1 | Qualifies `in_x`, `in_y` and `in_q` on this edge |
| in_x | input | 32 | Signed operand added to `in_y` |
| in_y | input | 32 | Signed operand that is summed and also scaled |
| in_q | input | 32 | Signed selector compared against the key 3 |
| out_valid | output | 1 | High when `out_j` holds a result |
| out_j | output | 32 | Low 32 bits of the final signed product |

## Verification
The bench uses directed words that separate the paths:
- An `in_x` near the positive limit makes the sum wrap, which exposes any widening of the sum.
- Values of `in_y` that are slightly negative, or that make the shift overflow into a negative number, show whether the clamp tests the wrapped value rather than the true product.
- Selector values of 3, 2 and `32'h80000003` separate a full-width compare from a compare on the low bits only.

Random operands mixed with random gaps in `in_valid` then exercise the products, the back-to-back flow and the three-cycle spacing. A reset pulsed in the middle of the stream shows whether in-flight samples are dropped.

// File: rtl/clamp_mul_pkg.sv
// Package: clamp_mul_pkg
// Shared constants and types for the clamped multiply dataflow pipeline.
// Assumes one result per accepted sample and a fixed pipeline depth.
package clamp_mul_pkg;

    // Number of register stages between input and output.
    localparam int STAGES = 3;

    // Which arm of the correction select was taken.
    typedef enum logic {
        SEL_MISS = 1'b0,
        SEL_HIT  = 1'b1
    } sel_e;

endpackage

// File: rtl/cmp_sum_stage.sv
// Module: cmp_sum_stage
// First register stage: forms the wrapped sum x+y and the shifted copy of y.
// It also forwards y and q for the next stage.
// Assumes the data registers need no reset; they load only on a valid sample.
module cmp_sum_stage #(
    parameter int W     = 32,
    parameter int SHIFT = 3
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] q_i,
    output logic [W-1:0] z_o,
    output logic [W-1:0] m_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] q_o
);

    // Capture the sum, the shift and the forwarded operands on a valid sample.
    always_ff @(posedge clk) begin
        if (load) begin
            z_o <= x_i + y_i;
            m_o <= y_i << SHIFT;
            y_o <= y_i;
            q_o <= q_i;
        end
    end

endmodule

// File: rtl/cmp_clamp_sel_stage.sv
// Module: cmp_clamp_sel_stage
// Second register stage: subtracts y from the shifted value and clamps a
// negative result to zero. In parallel it selects z+HIT or z-MISS depending
// on whether q equals KEY. Both arms are always computed (if-conversion).
// Assumes two's-complement wrap on every operation.
module cmp_clamp_sel_stage
    import clamp_mul_pkg::*;
#(
    parameter int W    = 32,
    parameter int KEY  = 3,
    parameter int HIT  = 5,
    parameter int MISS = 2
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] z_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] q_i,
    output logic [W-1:0] n_o,
    output logic [W-1:0] i_o
);

    logic [W-1:0] diff;
    logic [W-1:0] n_next;
    logic [W-1:0] arm_hit;
    logic [W-1:0] arm_miss;
    logic [W-1:0] i_next;
    sel_e         sel;

    // Shift-subtract followed by the non-negative clamp.
    always_comb begin
        diff   = m_i - y_i;
        n_next = diff[W-1] ? '0 : diff;
    end

    // Both correction arms, then the select on a full-width key compare.
    always_comb begin
        arm_hit  = z_i + W'(HIT);
        arm_miss = z_i - W'(MISS);
        sel      = (q_i == W'(KEY)) ? SEL_HIT : SEL_MISS;
        i_next   = (sel == SEL_HIT) ? arm_hit : arm_miss;
    end

    // Register the clamped value and the corrected sum on a valid sample.
    always_ff @(posedge clk) begin
        if (load) begin
            n_o <= n_next;
            i_o <= i_next;
        end
    end

endmodule

// File: rtl/cmp_mul_stage.sv
// Module: cmp_mul_stage
// Third register stage: keeps the low W bits of n*i. The low half of a
// product is the same for signed and unsigned operands, so one W-bit
// multiply is enough.
module cmp_mul_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] i_i,
    output logic [W-1:0] j_o
);

    logic [W-1:0] prod;

    // Truncated product.
    always_comb begin
        prod = n_i * i_i;
    end

    // Register the product on a valid sample.
    always_ff @(posedge clk) begin
        if (load) begin
            j_o <= prod;
        end
    end

endmodule

// File: rtl/cmp_valid_chain.sv
// Module: cmp_valid_chain
// Valid bits that travel alongside the data stages. Bit k is the valid bit
// of stage k+1. Reset is synchronous and active low, and it clears every bit.
module cmp_valid_chain #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    output logic [N-1:0] v_o
);

    generate
        if (N == 1) begin : g_single
            // Single-stage valid register.
            always_ff @(posedge clk) begin
                if (!rst_n) v_o <= 1'b0;
                else        v_o <= v_i;
            end
        end else begin : g_multi
            // Shift the valid bit one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) v_o <= '0;
                else        v_o <= {v_o[N-2:0], v_i};
            end
        end
    endgenerate

endmodule

// File: rtl/clamp_mul_pipe.sv
// Module: clamp_mul_pipe
// Top of the clamped multiply dataflow pipeline.
// Computes j = clamp0(7*y) * (q==KEY ? x+y+HIT : x+y-MISS), modulo 2^W.
// There are three stages and no backpressure; one sample can enter per cycle.
// Assumes the consumer always accepts out_j while out_valid is high.
module clamp_mul_pipe
    import clamp_mul_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHIFT = 3,
    parameter int KEY   = 3,
    parameter int HIT   = 5,
    parameter int MISS  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_q,
    output logic         out_valid,
    output logic [W-1:0] out_j
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] vld;
    logic              s1_valid;
    logic              s2_valid;
    logic [W-1:0]      s1_z, s1_m, s1_y, s1_q;
    logic [W-1:0]      s2_n, s2_i;

    assign s1_valid  = vld[0];
    assign s2_valid  = vld[1];
    assign out_valid = vld[LAST];

    cmp_valid_chain #(.N(STAGES)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .v_o   (vld)
    );

    cmp_sum_stage #(.W(W), .SHIFT(SHIFT)) u_s1 (
        .clk  (clk),
        .load (in_valid),
        .x_i  (in_x),
        .y_i  (in_y),
        .q_i  (in_q),
        .z_o  (s1_z),
        .m_o  (s1_m),
        .y_o  (s1_y),
        .q_o  (s1_q)
    );

    cmp_clamp_sel_stage #(.W(W), .KEY(KEY), .HIT(HIT), .MISS(MISS)) u_s2 (
        .clk  (clk),
        .load (s1_valid),
        .z_i  (s1_z),
        .m_i  (s1_m),
        .y_i  (s1_y),
        .q_i  (s1_q),
        .n_o  (s2_n),
        .i_o  (s2_i)
    );

    cmp_mul_stage #(.W(W)) u_s3 (
        .clk  (clk),
        .load (s2_valid),
        .n_i  (s2_n),
        .i_i  (s2_i),
        .j_o  (out_j)
    );

endmodule

// File: rtl/clamp_mul_pipe_chk.sv
// Module: clamp_mul_pipe_chk
// Assertion checker bound into clamp_mul_pipe. A counter of edges since reset
// makes sure no $past reaches back across a reset.
module clamp_mul_pipe_chk #(
    parameter int W     = 32,
    parameter int SHIFT = 3,
    parameter int KEY   = 3,
    parameter int HIT   = 5,
    parameter int MISS  = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_x,
    input logic [W-1:0] in_y,
    input logic [W-1:0] in_q,
    input logic         out_valid,
    input logic [W-1:0] out_j,
    input logic         s1_valid,
    input logic [W-1:0] s1_z,
    input logic         s2_valid,
    input logic [W-1:0] s2_n,
    input logic [W-1:0] s2_i
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    function automatic logic [W-1:0] ref_n(input logic [W-1:0] y);
        logic [W-1:0] t;
        t = y * W'((1 << SHIFT) - 1);
        return t[W-1] ? '0 : t;
    endfunction

    function automatic logic [W-1:0] ref_i(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [W-1:0] q);
        return (q == W'(KEY)) ? (x + y + W'(HIT)) : (x + y - W'(MISS));
    endfunction

    assert_sum_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && s1_valid) |-> s1_z == $past(in_x) + $past(in_y));

    assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && s2_valid) |-> s2_n == ref_n($past(in_y, 2)));

    assert_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && s2_valid)
            |-> s2_i == ref_i($past(in_x, 2), $past(in_y, 2), $past(in_q, 2)));

    assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid)
            |-> out_j == W'(ref_n($past(in_y, 3))
                            * ref_i($past(in_x, 3), $past(in_y, 3), $past(in_q, 3))));

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));

    assert_fresh_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> !out_valid);

endmodule

bind clamp_mul_pipe clamp_mul_pipe_chk #(
    .W(W), .SHIFT(SHIFT), .KEY(KEY), .HIT(HIT), .MISS(MISS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_y      (in_y),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_j     (out_j),
    .s1_valid  (s1_valid),
    .s1_z      (s1_z),
    .s2_valid  (s2_valid),
    .s2_n      (s2_n),
    .s2_i      (s2_i)
);

// File: tb/clamp_mul_pipe_test.sv
`timescale 1ns/1ps
module clamp_mul_pipe_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_x = '0, in_y = '0, in_q = '0;
    logic        out_valid;
    logic [31:0] out_j;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side model of what is in flight: entry 2 is at the output.
    logic        pv [3];
    logic [31:0] pj [3];
    string       pt [3];

    always #2.5 clk = ~clk;

    clamp_mul_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_q(in_q),
        .out_valid(out_valid), .out_j(out_j)
    );

    // Reference: scaled by a true multiply by seven, wrapped, then clamped.
    function automatic logic [31:0] exp_j(input logic [31:0] x, input logic [31:0] y,
                                          input logic [31:0] q);
        logic signed [31:0] n, i, z;
        z = $signed(x) + $signed(y);
        n = $signed(y) * 32'sd7;
        if (n < 0) n = 0;
        if (q == 32'd3) i = z + 32'sd5;
        else            i = z - 32'sd2;
        return n * i;
    endfunction

    // One cycle: drive at negedge, advance the model at posedge, check at negedge.
    task automatic step(input logic rst, input logic v, input logic [31:0] x,
                        input logic [31:0] y, input logic [31:0] q, input string tag);
        rst_n = rst; in_valid = v; in_x = x; in_y = y; in_q = q;
        @(posedge clk);
        if (!rst) begin
            for (int k = 0; k < 3; k++) pv[k] = 1'b0;
        end else begin
            pv[2] = pv[1]; pj[2] = pj[1]; pt[2] = pt[1];
            pv[1] = pv[0]; pj[1] = pj[0]; pt[1] = pt[0];
            pv[0] = v;     pj[0] = exp_j(x, y, q); pt[0] = tag;
        end
        @(negedge clk);
        checks++;
        if (out_valid !== pv[2]) begin
            errors++;
            $display("FAIL R5/R6/R7 out_valid=%b expected %b", out_valid, pv[2]);
        end
        if (pv[2] && out_valid === 1'b1) begin
            checks++;
            if (out_j !== pj[2]) begin
                errors++;
                $display("FAIL %s out_j=%h expected %h", pt[2], out_j, pj[2]);
            end
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pj[k] = '0; pt[k] = ""; end
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R7: hold reset with valid inputs offered; output must stay idle.
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 32'd1, 32'd1, 32'd3, "R7");
        // R1: sum wraps at the positive limit.
        step(1'b1, 1'b1, 32'h7fffffff, 32'd1, 32'd0, "R1");
        // R2: negative scaled value clamps; shift overflow into negative clamps.
        step(1'b1, 1'b1, 32'd10, 32'hffffffff, 32'd3, "R2");
        step(1'b1, 1'b1, 32'd10, 32'h20000000, 32'd3, "R2");
        step(1'b1, 1'b1, 32'd10, 32'h12345678, 32'd3, "R2");
        // R3: key hit, near miss, and a word whose low bits equal the key.
        step(1'b1, 1'b1, 32'd100, 32'd4, 32'd3, "R3");
        step(1'b1, 1'b1, 32'd100, 32'd4, 32'd2, "R3");
        step(1'b1, 1'b1, 32'd100, 32'd4, 32'h80000003, "R3");
        // R4: large product that overflows 32 bits.
        step(1'b1, 1'b1, 32'h40000000, 32'h0fffffff, 32'd7, "R4");
        // R6: gaps between samples.
        step(1'b1, 1'b0, 32'hdeadbeef, 32'd9, 32'd3, "R6");
        step(1'b1, 1'b1, 32'hfffffff0, 32'd9, 32'd3, "R6");
        step(1'b1, 1'b0, 32'd0, 32'd0, 32'd0, "R6");
        step(1'b1, 1'b0, 32'd0, 32'd0, 32'd0, "R6");
        // R7: reset in the middle of a stream drops in-flight samples.
        step(1'b1, 1'b1, 32'd1, 32'd2, 32'd3, "R7");
        step(1'b1, 1'b1, 32'd3, 32'd4, 32'd3, "R7");
        step(1'b0, 1'b1, 32'd5, 32'd6, 32'd3, "R7");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 32'd0, 32'd0, 32'd0, "R7");
        // Random stream, mostly back-to-back (R4, R5, R6).
        for (int k = 0; k < 400; k++) begin
            logic [31:0] rx, ry, rq;
            logic        rv;
            rv = ($urandom % 4) != 0;
            rx = $urandom;
            ry = ($urandom % 2) ? ($urandom % 2048) - 1024 : $urandom;
            rq = ($urandom % 3 == 0) ? 32'd3 : (($urandom % 2) ? $urandom % 8 : $urandom);
            step(1'b1, rv, rx, ry, rq, "R4");
        end
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 32'd0, 32'd0, 32'd0, "R6");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule